// File: doc/BRIEF.md
# Power Event Status and SCI Generator

This block holds the latched power-management event flags, their interrupt enables and a small general-purpose event byte pair. It drives one level-sensitive system control interrupt (SCI). Hardware sources set flags through single-cycle set inputs: a periodic timer, bus-master activity, a global-lock release, the power button, the sleep button, an alarm and a wake indication. Software reads the flags over a simple register bus and acknowledges the clearable ones by writing ones to them.

The interrupt line is a pure level. It is high while any enabled event is pending and falls as soon as software clears the last flag or drops the last enable. A set that arrives in the same cycle as a software clear of the same flag is kept, so no event can be lost. Event-word registers accept only 16-bit accesses. The general-purpose registers accept only byte accesses. Any other access is reported on a one-cycle error flag and changes nothing.

Top module: `pm_event_sci`

## Requirements
- R1: After reset every flag, enable and general-purpose register reads as zero, `sciLevel` is low and `regRdata` and `regErr` are zero.
- R2: The event word at offset 0 holds timer at bit 0, bus-master at bit 4, global at bit 5, power button at bit 8, sleep button at bit 9, alarm at bit 10 and wake at bit 15. A one-cycle pulse on a set input (including `pwrBtnPulse`) sets its bit, and the bit stays set until cleared.
- R3: Writing the event word clears exactly those bits written as 1 among bits 4, 8, 9, 10 and 15. Bits 0 and 5 are unaffected by any write.
- R4: The enable word sits at offset 2. A write stores the data ANDed with mask 0x0520 (bits 5, 8, 10). Every other enable bit reads 0, and the enable word changes only on a legal write to it.
- R5: `sciLevel` is high exactly when some bit among 0, 5, 8, 9 and 10 is set in both the event word and the enable word, or when the general-purpose status and enable bytes share a set bit. It reflects every register change in the cycle after the causing edge.
- R6: If a set input and a software clear hit the same flag (event word or general-purpose byte) in the same cycle, the flag ends up set.
- R7: The general-purpose status byte at offset 4 is set by `gpRaise` bits and cleared by written ones, both limited to the valid mask `GP_VALID` (default 0x2D). Bits outside the mask always read 0.
- R8: The general-purpose enable byte at offset 5 stores the written data ANDed with `GP_VALID`.
- R9: Size codes are 0 for byte, 1 for 16-bit, 2 for 32-bit and 3 reserved. Offsets 0 and 2 need code 1, and offsets 4 and 5 need code 0. Any other size, or any of the offsets 1, 3, 6 and 7, raises `regErr`, leaves every register unchanged and returns zero read data.
- R10: Read data and `regErr` appear in the cycle after the strobe. `regRdata` is zero in any cycle that does not follow a legal read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Register offset |
| regRd | input | 1 | Read strobe |
| regWr | input | 1 | Write strobe |
| regSize | input | 2 | Access size code |
| regWdata | input | 16 | Write data |
| pwrBtnPulse | input | 1 | Power button event |
| timerSet | input | 1 | Timer event set |
| busMasterSet | input | 1 | Bus-master event set |
| globalSet | input | 1 | Global-lock event set |
| sleepBtnSet | input | 1 | Sleep button event set |
| alarmSet | input | 1 | Alarm event set |
| wakeSet | input | 1 | Wake event set |
| gpRaise | input | GP_BITS | General-purpose event raise, one bit per event |
| regRdata | output | 16 | Read data, one cycle after the read |
| regErr | output | 1 | Access error, one cycle after the access |
| sciLevel | output | 1 | Level interrupt request |

## Verification
On every cycle the assertions check several rules. A power-button pulse always leaves its flag set, and a set beats a same-cycle clear. The timer flag never drops once set. The enable word holds without a legal write. An illegal access never produces a write strobe. An enabled general-purpose raise always lifts the interrupt. Idle cycles return zero read data. Only the bench scenarios can show the full interrupt truth table across flag and enable combinations, the exact read-back masks of every register, and the recovery of the line once each cause is cleared.

// File: rtl/pm_event_pkg.sv
package pm_event_pkg;

  localparam int REG_W = 16;

  // Event word bit positions
  localparam int POS_TIMER  = 0;
  localparam int POS_BUSM   = 4;
  localparam int POS_GLOBAL = 5;
  localparam int POS_PWRBTN = 8;
  localparam int POS_SLPBTN = 9;
  localparam int POS_ALARM  = 10;
  localparam int POS_WAKE   = 15;

  localparam logic [REG_W-1:0] CLR_MASK  = 16'h8710; // software-clearable flags
  localparam logic [REG_W-1:0] ENA_MASK  = 16'h0520; // writable enables
  localparam logic [REG_W-1:0] PAIR_MASK = 16'h0721; // flag/enable pairs feeding the interrupt

  // Register offsets
  localparam int OFF_STAT   = 0;
  localparam int OFF_ENA    = OFF_STAT + 2;
  localparam int OFF_GPSTAT = 4;
  localparam int OFF_GPENA  = 5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  typedef enum logic [2:0] {
    SEL_NONE   = 3'd0,
    SEL_STAT   = 3'd1,
    SEL_ENA    = 3'd2,
    SEL_GPSTAT = 3'd3,
    SEL_GPENA  = 3'd4
  } rdSel_e;

  typedef struct packed {
    logic   wrStat;
    logic   wrEna;
    logic   wrGpStat;
    logic   wrGpEna;
    logic   rdEn;
    rdSel_e rdSel;
    logic   accErr;
  } regStrb_t;

  typedef struct packed {
    logic timer;
    logic busMaster;
    logic global;
    logic pwrBtn;
    logic sleepBtn;
    logic alarm;
    logic wake;
  } hwSet_t;

endpackage

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
  import pm_event_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [1:0]        regSize,
  output regStrb_t          strb,
  output logic              regErr
);

  logic hitStat, hitEna, hitGpStat, hitGpEna;
  logic isHalf, isByte, legal, access;

  always_comb begin
    hitStat   = (regAddr == ADDR_W'(OFF_STAT));
    hitEna    = (regAddr == ADDR_W'(OFF_ENA));
    hitGpStat = (regAddr == ADDR_W'(OFF_GPSTAT));
    hitGpEna  = (regAddr == ADDR_W'(OFF_GPENA));
    isHalf    = (regSize == SZ_HALF);
    isByte    = (regSize == SZ_BYTE);
    legal     = ((hitStat || hitEna) && isHalf) || ((hitGpStat || hitGpEna) && isByte);
    access    = regRd || regWr;

    strb.wrStat   = regWr && legal && hitStat;
    strb.wrEna    = regWr && legal && hitEna;
    strb.wrGpStat = regWr && legal && hitGpStat;
    strb.wrGpEna  = regWr && legal && hitGpEna;
    strb.rdEn     = regRd && legal;
    strb.accErr   = access && !legal;
    if (!legal)         strb.rdSel = SEL_NONE;
    else if (hitStat)   strb.rdSel = SEL_STAT;
    else if (hitEna)    strb.rdSel = SEL_ENA;
    else if (hitGpStat) strb.rdSel = SEL_GPSTAT;
    else                strb.rdSel = SEL_GPENA;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) regErr <= 1'b0;
    else        regErr <= strb.accErr;
  end

  AST_ONE_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.wrStat, strb.wrEna, strb.wrGpStat, strb.wrGpEna})); // R9

  AST_BAD_SIZE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ((regRd || regWr) && (regSize == SZ_WORD || regSize == SZ_RSVD)) |=> regErr); // R9

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    strb.accErr |-> !(strb.wrStat || strb.wrEna || strb.wrGpStat || strb.wrGpEna)); // R9

endmodule

// File: rtl/pm_event_dp.sv
module pm_event_dp
  import pm_event_pkg::*;
#(
  parameter int               GP_BITS  = 8,
  parameter logic [GP_BITS-1:0] GP_VALID = 8'h2D
) (
  input  logic               clk,
  input  logic               rst_n,
  input  regStrb_t           strb,
  input  logic [REG_W-1:0]   wdata,
  input  hwSet_t             hw,
  input  logic [GP_BITS-1:0] gpRaise,
  output logic [REG_W-1:0]   rdata,
  output logic               sciLevel
);

  logic [REG_W-1:0]   statQ, enaQ, setVec, statNext, enaNext, statClr;
  logic [GP_BITS-1:0] gpStatQ, gpEnaQ, gpStatNext, gpEnaNext, gpClr, gpWr;
  logic [REG_W-1:0]   rdMux;
  logic               pairHit, gpHit;

  always_comb begin
    setVec             = '0;
    setVec[POS_TIMER]  = hw.timer;
    setVec[POS_BUSM]   = hw.busMaster;
    setVec[POS_GLOBAL] = hw.global;
    setVec[POS_PWRBTN] = hw.pwrBtn;
    setVec[POS_SLPBTN] = hw.sleepBtn;
    setVec[POS_ALARM]  = hw.alarm;
    setVec[POS_WAKE]   = hw.wake;
  end

  // Sets are ORed after the clear so a coincident set survives
  always_comb begin
    statClr    = strb.wrStat ? (wdata & CLR_MASK) : '0;
    statNext   = (statQ & ~statClr) | setVec;
    enaNext    = strb.wrEna ? (wdata & ENA_MASK) : enaQ;
    gpWr       = wdata[GP_BITS-1:0] & GP_VALID;
    gpClr      = strb.wrGpStat ? gpWr : '0;
    gpStatNext = (gpStatQ & ~gpClr) | (gpRaise & GP_VALID);
    gpEnaNext  = strb.wrGpEna ? gpWr : gpEnaQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statQ   <= '0;
      enaQ    <= '0;
      gpStatQ <= '0;
      gpEnaQ  <= '0;
    end else begin
      statQ   <= statNext;
      enaQ    <= enaNext;
      gpStatQ <= gpStatNext;
      gpEnaQ  <= gpEnaNext;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_STAT:   rdMux = statQ;
      SEL_ENA:    rdMux = enaQ;
      SEL_GPSTAT: rdMux = REG_W'(gpStatQ);
      SEL_GPENA:  rdMux = REG_W'(gpEnaQ);
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         rdata <= '0;
    else if (strb.rdEn) rdata <= rdMux;
    else                rdata <= '0;
  end

  assign pairHit  = |(statQ & enaQ & PAIR_MASK);
  assign gpHit    = |(gpStatQ & gpEnaQ);
  assign sciLevel = pairHit || gpHit;

  AST_PWRBTN_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    hw.pwrBtn |=> statQ[POS_PWRBTN]); // R2

  AST_TIMER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    statQ[POS_TIMER] |=> statQ[POS_TIMER]); // R3

  AST_ENA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.wrEna |=> $stable(enaQ)); // R4

  AST_GP_RAISE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(gpRaise & gpEnaQ & GP_VALID)) && !strb.wrGpEna) |=> sciLevel); // R5

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (hw.alarm && strb.wrStat) |=> statQ[POS_ALARM]); // R6

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.rdEn |=> (rdata == '0)); // R10

endmodule

// File: rtl/pm_event_sci.sv
module pm_event_sci
  import pm_event_pkg::*;
#(
  parameter int                 ADDR_W   = 3,
  parameter int                 GP_BITS  = 8,
  parameter logic [GP_BITS-1:0] GP_VALID = 8'h2D
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regRd,
  input  logic               regWr,
  input  logic [1:0]         regSize,
  input  logic [15:0]        regWdata,
  input  logic               pwrBtnPulse,
  input  logic               timerSet,
  input  logic               busMasterSet,
  input  logic               globalSet,
  input  logic               sleepBtnSet,
  input  logic               alarmSet,
  input  logic               wakeSet,
  input  logic [GP_BITS-1:0] gpRaise,
  output logic [15:0]        regRdata,
  output logic               regErr,
  output logic               sciLevel
);

  regStrb_t strb;
  hwSet_t   hw;

  assign hw = '{timer: timerSet, busMaster: busMasterSet, global: globalSet,
                pwrBtn: pwrBtnPulse, sleepBtn: sleepBtnSet, alarm: alarmSet,
                wake: wakeSet};

  pm_event_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .regAddr (regAddr),
    .regRd   (regRd),
    .regWr   (regWr),
    .regSize (regSize),
    .strb    (strb),
    .regErr  (regErr)
  );

  pm_event_dp #(.GP_BITS(GP_BITS), .GP_VALID(GP_VALID)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .wdata    (regWdata),
    .hw       (hw),
    .gpRaise  (gpRaise),
    .rdata    (regRdata),
    .sciLevel (sciLevel)
  );

endmodule

// File: tb/pm_event_sci_tb.sv
module pm_event_sci_tb_top;

  localparam logic [7:0] VALID = 8'h2D;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regRd = 1'b0, regWr = 1'b0;
  logic [1:0]  regSize = '0;
  logic [15:0] regWdata = '0;
  logic        pwrBtnPulse = 0, timerSet = 0, busMasterSet = 0, globalSet = 0;
  logic        sleepBtnSet = 0, alarmSet = 0, wakeSet = 0;
  logic [7:0]  gpRaise = '0;
  logic [15:0] regRdata;
  logic        regErr, sciLevel;

  int nChecks = 0;
  int nFails  = 0;

  logic [15:0] mStat = '0, mEna = '0;
  logic [7:0]  mGpS = '0, mGpE = '0;

  always #2 clk = ~clk;

  pm_event_sci #(.ADDR_W(3), .GP_BITS(8), .GP_VALID(VALID)) dut_i (.*);

  function automatic logic expSci();
    return ((mStat & mEna & 16'h0721) != 0) || ((mGpS & mGpE) != 0);
  endfunction

  function automatic logic isLegal(input logic [2:0] a, input logic [1:0] sz);
    return ((a == 3'd0 || a == 3'd2) && sz == 2'd1) || ((a == 3'd4 || a == 3'd5) && sz == 2'd0);
  endfunction

  function automatic logic [15:0] modelRead(input logic [2:0] a);
    case (a)
      3'd0:    return mStat;
      3'd2:    return mEna;
      3'd4:    return {8'h00, mGpS};
      3'd5:    return {8'h00, mGpE};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One register access; checks error, read data and interrupt level the cycle after
  task automatic access(input bit isWr, input logic [2:0] a, input logic [1:0] sz,
                        input logic [15:0] d, input string req);
    logic [15:0] expRd;
    logic        ok;
    ok    = isLegal(a, sz);
    expRd = (!isWr && ok) ? modelRead(a) : 16'h0000;
    regAddr = a; regSize = sz; regWdata = d; regRd = !isWr; regWr = isWr;
    step();
    regRd = 1'b0; regWr = 1'b0;
    if (isWr && ok) begin
      case (a)
        3'd0: mStat = mStat & ~(d & 16'h8710);
        3'd2: mEna  = d & 16'h0520;
        3'd4: mGpS  = mGpS & ~(d[7:0] & VALID);
        3'd5: mGpE  = d[7:0] & VALID;
        default: ;
      endcase
    end
    chk({req, " err"}, 32'(regErr), 32'(!ok));
    if (!isWr) chk({req, " rdata"}, 32'(regRdata), 32'(expRd));
    chk({req, " sci"}, 32'(sciLevel), 32'(expSci()));
  endtask

  // Pulse one hardware set source: 0 timer,1 busM,2 global,3 pwrBtn,4 sleep,5 alarm,6 wake
  task automatic pulse(input int src);
    case (src)
      0: begin timerSet = 1;     mStat[0]  = 1'b1; end
      1: begin busMasterSet = 1; mStat[4]  = 1'b1; end
      2: begin globalSet = 1;    mStat[5]  = 1'b1; end
      3: begin pwrBtnPulse = 1;  mStat[8]  = 1'b1; end
      4: begin sleepBtnSet = 1;  mStat[9]  = 1'b1; end
      5: begin alarmSet = 1;     mStat[10] = 1'b1; end
      default: begin wakeSet = 1; mStat[15] = 1'b1; end
    endcase
    step();
    {timerSet, busMasterSet, globalSet, pwrBtnPulse, sleepBtnSet, alarmSet, wakeSet} = '0;
    chk("R5 sci after set", 32'(sciLevel), 32'(expSci()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", 32'(regRdata), 0);
    chk("R1 reset err", 32'(regErr), 0);
    chk("R1 reset sci", 32'(sciLevel), 0);
    rst_n = 1'b1;
    @(negedge clk);
    access(0, 3'd0, 2'd1, 0, "R1 stat");
    access(0, 3'd2, 2'd1, 0, "R1 ena");
    access(0, 3'd4, 2'd0, 0, "R1 gpstat");
    access(0, 3'd5, 2'd0, 0, "R1 gpena");

    // R4: single-bit enable sweep
    for (int i = 0; i < 16; i++) begin
      access(1, 3'd2, 2'd1, 16'(1 << i), "R4 ena write");
      access(0, 3'd2, 2'd1, 0, "R4 ena read");
    end
    access(1, 3'd2, 2'd1, 16'hFFFF, "R4 ena all");
    access(0, 3'd2, 2'd1, 0, "R4 ena mask");
    access(1, 3'd2, 2'd1, 16'h0000, "R4 ena zero");

    // R2 / R3: each clearable source latches and clears by written one
    for (int s = 1; s < 7; s++) begin
      if (s == 2) continue;
      pulse(s);
      step();
      access(0, 3'd0, 2'd1, 0, "R2 latched flag");
      access(1, 3'd0, 2'd1, 16'hFFFF, "R3 clear");
      access(0, 3'd0, 2'd1, 0, "R3 cleared");
    end

    // R5: flag subsets {pwrBtn, alarm, sleep} x enable subsets {global, pwrBtn, alarm}
    for (int st = 0; st < 8; st++) begin
      for (int en = 0; en < 8; en++) begin
        logic [15:0] ev;
        ev = 16'h0000;
        if (en[0]) ev[5]  = 1'b1;
        if (en[1]) ev[8]  = 1'b1;
        if (en[2]) ev[10] = 1'b1;
        access(1, 3'd2, 2'd1, ev, "R5 ena");
        if (st[0]) pulse(3);
        if (st[1]) pulse(5);
        if (st[2]) pulse(4);
        access(0, 3'd0, 2'd1, 0, "R5 flags");
        access(1, 3'd0, 2'd1, 16'hFFFF, "R5 clear drops sci");
      end
    end

    // R6: set beats same-cycle clear
    access(1, 3'd2, 2'd1, 16'h0500, "R6 ena");
    pwrBtnPulse = 1; alarmSet = 1;
    regAddr = 3'd0; regSize = 2'd1; regWdata = 16'hFFFF; regWr = 1;
    step();
    regWr = 0; pwrBtnPulse = 0; alarmSet = 0;
    mStat = (mStat & ~16'h8710) | 16'h0500;
    chk("R6 sci", 32'(sciLevel), 1);
    access(0, 3'd0, 2'd1, 0, "R6 flags kept");
    access(1, 3'd0, 2'd1, 16'hFFFF, "R6 clear after");
    access(1, 3'd2, 2'd1, 16'h0000, "R6 ena off");

    // R7: raise each GP bit, then clear
    for (int b = 0; b < 8; b++) begin
      gpRaise = 8'(1 << b);
      step();
      gpRaise = '0;
      mGpS = mGpS | (8'(1 << b) & VALID);
      access(0, 3'd4, 2'd0, 0, "R7 raise");
    end
    access(1, 3'd4, 2'd0, 16'h0005, "R7 partial clear");
    access(0, 3'd4, 2'd0, 0, "R7 partial read");
    // R6 for GP byte: raise and clear same cycle
    gpRaise = 8'h20; regAddr = 3'd4; regSize = 2'd0; regWdata = 16'h00FF; regWr = 1;
    step();
    regWr = 0; gpRaise = '0;
    mGpS = 8'h20;
    access(0, 3'd4, 2'd0, 0, "R6 gp set wins");
    access(1, 3'd4, 2'd0, 16'h00FF, "R7 clear all");

    // R8: full enable byte sweep
    for (int v = 0; v < 256; v++) begin
      access(1, 3'd5, 2'd0, 16'(v), "R8 gpena write");
      access(0, 3'd5, 2'd0, 0, "R8 gpena read");
    end
    // R5: GP pairs
    access(1, 3'd5, 2'd0, 16'h00FF, "R5 gp ena");
    for (int b = 0; b < 8; b++) begin
      gpRaise = 8'(1 << b);
      step();
      gpRaise = '0;
      mGpS = mGpS | (8'(1 << b) & VALID);
      chk("R5 gp sci", 32'(sciLevel), 32'(expSci()));
      access(1, 3'd4, 2'd0, 16'h00FF, "R5 gp clear");
    end
    access(1, 3'd5, 2'd0, 16'h0000, "R5 gp ena off");

    // R9: size and address legality
    access(1, 3'd2, 2'd1, 16'h0400, "R9 ena prime");
    for (int a = 0; a < 8; a++) begin
      for (int sz = 0; sz < 4; sz++) begin
        access(0, 3'(a), 2'(sz), 0, "R9 read legality");
        if (!isLegal(3'(a), 2'(sz))) begin
          access(1, 3'(a), 2'(sz), 16'h00FF, "R9 illegal write");
          access(0, 3'd2, 2'd1, 0, "R9 ena untouched");
          access(0, 3'd5, 2'd0, 0, "R9 gpena untouched");
        end
      end
    end
    access(1, 3'd2, 2'd1, 16'h0000, "R9 ena clear");

    // R10: data lasts one cycle only
    access(1, 3'd2, 2'd1, 16'h0020, "R10 ena");
    access(0, 3'd2, 2'd1, 0, "R10 read");
    step();
    chk("R10 rdata idle", 32'(regRdata), 0);
    chk("R10 err idle", 32'(regErr), 0);
    access(1, 3'd2, 2'd1, 16'h0000, "R10 ena off");

    // R3: timer and global cannot be cleared
    pulse(0);
    pulse(2);
    access(1, 3'd0, 2'd1, 16'hFFFF, "R3 sticky write");
    access(0, 3'd0, 2'd1, 0, "R3 sticky read");
    access(1, 3'd2, 2'd1, 16'h0020, "R5 global pair");
    access(1, 3'd2, 2'd1, 16'h0000, "R5 global off");

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule